// File: doc/BRIEF.md
# Exception Entry Sequencer

This block computes and commits the control-register and program-counter updates that a small processor core makes when it takes an exception or an interrupt. On each cycle in which the request strobe is high, it samples a cause code, the current PC and the current status, estatus, bstatus, EA, BA and TLB-control registers. In the following cycle it presents the complete set of next values together with a one-cycle commit pulse, and the core copies them into its register file and fetch unit.

The request is a plain control strobe, not a valid/ready stream. The block accepts a request on every cycle without back-pressure, because each entry is resolved in a single cycle. The nesting rules follow the exception-handler-active bit (EH) in status. A first-level entry saves the return state. A nested entry keeps the state saved by the outer level, except where a rule below says otherwise. A TLB miss goes to a separate fast vector when it is first-level and takes a double-miss path when it is nested. A break saves into its own bstatus and BA registers. A cause code that is not recognised, or an interrupt requested while interrupts are disabled, changes no register and sets a sticky error flag instead.

Top module: `exc_entry_seq`

## Requirements
- R1: Every taken entry asserts `commit_o` for exactly one cycle, in the cycle after the request. It clears status bit 0 (PIE) and bit 1 (U). It drives `exc_cause_o` with the request's cause code. It copies all other status bits, and every register that the rules below do not name, from the sampled inputs.
- R2: An interrupt (cause 1) with PIE=1 copies status into estatus, sets status bit 3 (IH), writes EA = PC + 4 and sets the PC to `VEC_GENERAL`. EH is not changed.
- R3: A TLB miss (cause 2) with status bit 2 (EH) = 0 copies status into estatus and sets EH. It clears TLB-control bit 1 (DBL), sets TLB-control bit 0 (WR), writes EA = PC + 4 and sets the PC to `VEC_FAST_MISS`.
- R4: A TLB miss with EH = 1 sets EH and DBL. It leaves estatus, EA and WR unchanged and sets the PC to `VEC_GENERAL`.
- R5: A permission fault (cause 3 read, 4 write, 5 execute) always copies status into estatus, writes EA = PC + 4, sets EH and sets the PC to `VEC_GENERAL`. It sets WR only when EH was 0 before entry.
- R6: A supervisor-only fault (cause 6) or a trap (cause 7) sets EH and sets the PC to `VEC_GENERAL`. It copies status into estatus and writes EA = PC + 4 only when EH was 0.
- R7: A break (cause 8) sets EH and sets the PC to `VEC_GENERAL`. It copies status into bstatus and writes BA = PC + 4 only when EH was 0. It never touches estatus or EA.
- R8: A request with any other cause code (0, or 9 to 31), or an interrupt with PIE = 0, raises no commit and leaves every output register at its previous value. It sets `cause_err_o`, which stays high until reset.
- R9: After reset, every output is 0.
- R10: PC + 4 wraps modulo 2^XLEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req_i | input | 1 | Exception request strobe |
| exc_cause_i | input | 5 | Cause code of the request |
| pc_i | input | XLEN | PC of the faulting instruction |
| status_i | input | XLEN | Current status |
| estatus_i | input | XLEN | Current estatus |
| bstatus_i | input | XLEN | Current bstatus |
| ea_i | input | XLEN | Current exception return address |
| ba_i | input | XLEN | Current break return address |
| tlbmisc_i | input | XLEN | Current TLB-control register |
| commit_o | output | 1 | One-cycle pulse: next values valid |
| status_o | output | XLEN | Next status |
| estatus_o | output | XLEN | Next estatus |
| bstatus_o | output | XLEN | Next bstatus |
| ea_o | output | XLEN | Next EA |
| ba_o | output | XLEN | Next BA |
| tlbmisc_o | output | XLEN | Next TLB-control register |
| exc_cause_o | output | 5 | Cause field for the exception register |
| pc_o | output | XLEN | Next PC (handler vector) |
| cause_err_o | output | 1 | Sticky illegal-request flag |

## Verification
Every result of this block, including the commit pulse and the error flag, comes out of one register stage. Each result is therefore due exactly one clock edge after the request is sampled. The bench drives a request at a falling edge, drops the strobe at the next falling edge and compares all outputs there, one edge later. In the same cycle it confirms that the commit pulse has cleared again by the following sample. For rejected requests, it compares the held outputs against the values of the last accepted entry at that same sample point.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int CAUSE_W = 5;

  localparam int ST_PIE = 0;
  localparam int ST_U   = 1;
  localparam int ST_EH  = 2;
  localparam int ST_IH  = 3;

  localparam int TM_WR  = 0;
  localparam int TM_DBL = 1;

  localparam logic [CAUSE_W-1:0] C_IRQ     = 5'd1;
  localparam logic [CAUSE_W-1:0] C_TLBMISS = 5'd2;
  localparam logic [CAUSE_W-1:0] C_PERM_RD = 5'd3;
  localparam logic [CAUSE_W-1:0] C_PERM_WR = 5'd4;
  localparam logic [CAUSE_W-1:0] C_PERM_EX = 5'd5;
  localparam logic [CAUSE_W-1:0] C_SUPV    = 5'd6;
  localparam logic [CAUSE_W-1:0] C_TRAP    = 5'd7;
  localparam logic [CAUSE_W-1:0] C_BREAK   = 5'd8;

  typedef enum logic [2:0] {
    K_IRQ, K_MISS, K_PERM, K_SOFT, K_BRK, K_BAD
  } kind_t;

  typedef enum logic {V_GEN, V_FAST} vsel_t;
endpackage

// File: rtl/exc_decode.sv
module exc_decode
  import exc_pkg::*;
(
  input  logic [CAUSE_W-1:0] cause_i,
  input  logic               pie_i,
  output kind_t              kind_o,
  output logic               legal_o
);
  always_comb begin
    unique case (cause_i)
      C_IRQ:                          kind_o = pie_i ? K_IRQ : K_BAD;
      C_TLBMISS:                      kind_o = K_MISS;
      C_PERM_RD, C_PERM_WR, C_PERM_EX: kind_o = K_PERM;
      C_SUPV, C_TRAP:                 kind_o = K_SOFT;
      C_BREAK:                        kind_o = K_BRK;
      default:                        kind_o = K_BAD;
    endcase
    legal_o = (kind_o != K_BAD);
  end
endmodule

// File: rtl/exc_next_calc.sv
module exc_next_calc
  import exc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  kind_t            kind_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  status_i,
  input  logic [XLEN-1:0]  estatus_i,
  input  logic [XLEN-1:0]  bstatus_i,
  input  logic [XLEN-1:0]  ea_i,
  input  logic [XLEN-1:0]  ba_i,
  input  logic [XLEN-1:0]  tlbmisc_i,
  output logic [XLEN-1:0]  status_o,
  output logic [XLEN-1:0]  estatus_o,
  output logic [XLEN-1:0]  bstatus_o,
  output logic [XLEN-1:0]  ea_o,
  output logic [XLEN-1:0]  ba_o,
  output logic [XLEN-1:0]  tlbmisc_o,
  output vsel_t            vsel_o
);
  localparam logic [XLEN-1:0] RET_STEP = XLEN'(4);

  logic            nested;
  logic [XLEN-1:0] ret_addr;

  assign nested   = status_i[ST_EH];
  assign ret_addr = pc_i + RET_STEP;

  always_comb begin
    status_o          = status_i;
    status_o[ST_PIE]  = 1'b0;
    status_o[ST_U]    = 1'b0;
    estatus_o         = estatus_i;
    bstatus_o         = bstatus_i;
    ea_o              = ea_i;
    ba_o              = ba_i;
    tlbmisc_o         = tlbmisc_i;
    vsel_o            = V_GEN;
    unique case (kind_i)
      K_IRQ: begin
        status_o[ST_IH] = 1'b1;
        estatus_o       = status_i;
        ea_o            = ret_addr;
      end
      K_MISS: begin
        status_o[ST_EH] = 1'b1;
        if (!nested) begin
          estatus_o         = status_i;
          ea_o              = ret_addr;
          tlbmisc_o[TM_WR]  = 1'b1;
          tlbmisc_o[TM_DBL] = 1'b0;
          vsel_o            = V_FAST;
        end else begin
          tlbmisc_o[TM_DBL] = 1'b1;
        end
      end
      K_PERM: begin
        status_o[ST_EH] = 1'b1;
        estatus_o       = status_i;
        ea_o            = ret_addr;
        if (!nested) tlbmisc_o[TM_WR] = 1'b1;
      end
      K_SOFT: begin
        status_o[ST_EH] = 1'b1;
        if (!nested) begin
          estatus_o = status_i;
          ea_o      = ret_addr;
        end
      end
      K_BRK: begin
        status_o[ST_EH] = 1'b1;
        if (!nested) begin
          bstatus_o = status_i;
          ba_o      = ret_addr;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter int              XLEN          = 32,
  parameter logic [XLEN-1:0] VEC_GENERAL   = '0,
  parameter logic [XLEN-1:0] VEC_FAST_MISS = '0
) (
  input  vsel_t           vsel_i,
  output logic [XLEN-1:0] pc_o
);
  always_comb begin
    unique case (vsel_i)
      V_FAST:  pc_o = VEC_FAST_MISS;
      default: pc_o = VEC_GENERAL;
    endcase
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int              XLEN          = 32,
  parameter logic [XLEN-1:0] VEC_GENERAL   = 32'h0000_0120,
  parameter logic [XLEN-1:0] VEC_FAST_MISS = 32'h0000_0200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               exc_req_i,
  input  logic [4:0]         exc_cause_i,
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    status_i,
  input  logic [XLEN-1:0]    estatus_i,
  input  logic [XLEN-1:0]    bstatus_i,
  input  logic [XLEN-1:0]    ea_i,
  input  logic [XLEN-1:0]    ba_i,
  input  logic [XLEN-1:0]    tlbmisc_i,
  output logic               commit_o,
  output logic [XLEN-1:0]    status_o,
  output logic [XLEN-1:0]    estatus_o,
  output logic [XLEN-1:0]    bstatus_o,
  output logic [XLEN-1:0]    ea_o,
  output logic [XLEN-1:0]    ba_o,
  output logic [XLEN-1:0]    tlbmisc_o,
  output logic [4:0]         exc_cause_o,
  output logic [XLEN-1:0]    pc_o,
  output logic               cause_err_o
);
  kind_t           kind;
  logic            legal;
  vsel_t           vsel;
  logic [XLEN-1:0] n_status, n_estatus, n_bstatus, n_ea, n_ba, n_tlb, n_pc;

  exc_decode u_decode (
    .cause_i (exc_cause_i),
    .pie_i   (status_i[ST_PIE]),
    .kind_o  (kind),
    .legal_o (legal)
  );

  exc_next_calc #(.XLEN(XLEN)) u_calc (
    .kind_i    (kind),
    .pc_i      (pc_i),
    .status_i  (status_i),
    .estatus_i (estatus_i),
    .bstatus_i (bstatus_i),
    .ea_i      (ea_i),
    .ba_i      (ba_i),
    .tlbmisc_i (tlbmisc_i),
    .status_o  (n_status),
    .estatus_o (n_estatus),
    .bstatus_o (n_bstatus),
    .ea_o      (n_ea),
    .ba_o      (n_ba),
    .tlbmisc_o (n_tlb),
    .vsel_o    (vsel)
  );

  exc_vector_sel #(
    .XLEN(XLEN), .VEC_GENERAL(VEC_GENERAL), .VEC_FAST_MISS(VEC_FAST_MISS)
  ) u_vec (
    .vsel_i (vsel),
    .pc_o   (n_pc)
  );

  logic take;
  assign take = exc_req_i && legal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit_o    <= 1'b0;
      status_o    <= '0;
      estatus_o   <= '0;
      bstatus_o   <= '0;
      ea_o        <= '0;
      ba_o        <= '0;
      tlbmisc_o   <= '0;
      exc_cause_o <= '0;
      pc_o        <= '0;
      cause_err_o <= 1'b0;
    end else begin
      commit_o <= take;
      if (take) begin
        status_o    <= n_status;
        estatus_o   <= n_estatus;
        bstatus_o   <= n_bstatus;
        ea_o        <= n_ea;
        ba_o        <= n_ba;
        tlbmisc_o   <= n_tlb;
        exc_cause_o <= exc_cause_i;
        pc_o        <= n_pc;
      end
      if (exc_req_i && !legal) cause_err_o <= 1'b1;
    end
  end

  assert_mode_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (!status_o[ST_PIE] && !status_o[ST_U]));

  assert_cause_field_R1: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i && legal |=> commit_o && exc_cause_o == $past(exc_cause_i));

  assert_irq_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i && exc_cause_i == C_IRQ && status_i[ST_PIE]
      |=> pc_o == VEC_GENERAL && status_o[ST_IH]);

  assert_fast_miss_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i && exc_cause_i == C_TLBMISS && !status_i[ST_EH]
      |=> pc_o == VEC_FAST_MISS && !tlbmisc_o[TM_DBL]);

  assert_double_miss_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i && exc_cause_i == C_TLBMISS && status_i[ST_EH]
      |=> pc_o == VEC_GENERAL && tlbmisc_o[TM_DBL] && ea_o == $past(ea_i));

  assert_reject_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req_i && !legal |=> !commit_o && cause_err_o && $stable(pc_o));

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cause_err_o |=> cause_err_o);
endmodule

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
  localparam int XLEN = 32;
  localparam logic [31:0] VGEN  = 32'h0000_0120;
  localparam logic [31:0] VFAST = 32'h0000_0200;

  logic clk = 0, rst_n = 0, req = 0;
  logic [4:0]  cause = 0;
  logic [31:0] pc = 0, st = 0, est = 0, bst = 0, ea = 0, ba = 0, tm = 0;
  logic        commit, err;
  logic [31:0] st_o, est_o, bst_o, ea_o, ba_o, tm_o, pc_o;
  logic [4:0]  cause_o;

  int n_tests = 0, n_fail = 0;

  always #2 clk = ~clk;

  exc_entry_seq #(.XLEN(XLEN), .VEC_GENERAL(VGEN), .VEC_FAST_MISS(VFAST)) u_dut (
    .clk(clk), .rst_n(rst_n), .exc_req_i(req), .exc_cause_i(cause),
    .pc_i(pc), .status_i(st), .estatus_i(est), .bstatus_i(bst),
    .ea_i(ea), .ba_i(ba), .tlbmisc_i(tm), .commit_o(commit),
    .status_o(st_o), .estatus_o(est_o), .bstatus_o(bst_o), .ea_o(ea_o),
    .ba_o(ba_o), .tlbmisc_o(tm_o), .exc_cause_o(cause_o), .pc_o(pc_o),
    .cause_err_o(err)
  );

  // expected state
  logic [31:0] x_st, x_est, x_bst, x_ea, x_ba, x_tm, x_pc;
  logic [4:0]  x_cause;
  logic        x_commit, x_err;

  // vector: {cause[4:0], status low nibble {IH,EH,U,PIE}}
  localparam logic [8:0] VECS [14] = '{
    {5'd1, 4'b0011}, {5'd1, 4'b0111}, {5'd2, 4'b0011}, {5'd2, 4'b0110},
    {5'd3, 4'b0010}, {5'd4, 4'b0101}, {5'd5, 4'b0000}, {5'd6, 4'b0011},
    {5'd6, 4'b0100}, {5'd7, 4'b1001}, {5'd7, 4'b0111}, {5'd8, 4'b0011},
    {5'd8, 4'b0110}, {5'd2, 4'b1111}
  };

  task automatic model(input string rq);
    logic eh;
    logic [31:0] ret;
    eh  = st[2];
    ret = pc + 32'd4;
    x_commit = 1;
    case (cause)
      5'd1: if (!st[0]) x_commit = 0;
      5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd8: ;
      default: x_commit = 0;
    endcase
    if (!x_commit) begin
      x_err = 1;  // R8: hold outputs
      return;
    end
    x_st = st & ~32'h3; x_est = est; x_bst = bst; x_ea = ea; x_ba = ba;
    x_tm = tm; x_pc = VGEN; x_cause = cause;
    case (cause)
      5'd1: begin x_st[3] = 1; x_est = st; x_ea = ret; end
      5'd2: begin
        x_st[2] = 1;
        if (!eh) begin x_est = st; x_ea = ret; x_tm[0] = 1; x_tm[1] = 0; x_pc = VFAST; end
        else x_tm[1] = 1;
      end
      5'd3, 5'd4, 5'd5: begin
        x_st[2] = 1; x_est = st; x_ea = ret; if (!eh) x_tm[0] = 1;
      end
      5'd6, 5'd7: begin
        x_st[2] = 1; if (!eh) begin x_est = st; x_ea = ret; end
      end
      default: begin
        x_st[2] = 1; if (!eh) begin x_bst = st; x_ba = ret; end
      end
    endcase
  endtask

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic check_all(input string rq);
    chk(rq, "commit", {31'd0, commit}, {31'd0, x_commit});
    chk(rq, "err", {31'd0, err}, {31'd0, x_err});
    chk(rq, "status", st_o, x_st);
    chk(rq, "estatus", est_o, x_est);
    chk(rq, "bstatus", bst_o, x_bst);
    chk(rq, "ea", ea_o, x_ea);
    chk(rq, "ba", ba_o, x_ba);
    chk(rq, "tlbmisc", tm_o, x_tm);
    chk(rq, "pc", pc_o, x_pc);
    chk(rq, "cause", {27'd0, cause_o}, {27'd0, x_cause});
  endtask

  task automatic fire(input string rq, input logic [4:0] c, input logic [31:0] s, input logic [31:0] p);
    @(negedge clk);
    cause = c; st = s; pc = p; req = 1;
    model(rq);
    @(negedge clk);
    req = 0;
    check_all(rq);
    @(negedge clk);
    chk(rq, "commit pulse width", {31'd0, commit}, 32'd0);
  endtask

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    est = 32'h0000_0E50; bst = 32'h0000_0B50; ea = 32'h0000_1EA0;
    ba = 32'h0000_1BA0; tm = 32'hF0F0_00A0;
    repeat (3) @(negedge clk);
    // R9: reset state
    x_st = 0; x_est = 0; x_bst = 0; x_ea = 0; x_ba = 0; x_tm = 0; x_pc = 0;
    x_cause = 0; x_commit = 0; x_err = 0;
    check_all("R9");
    rst_n = 1;

    for (int i = 0; i < 14; i++) begin
      string rq;
      case (VECS[i][8:4])
        5'd1: rq = "R2";
        5'd2: rq = VECS[i][2] ? "R4" : "R3";
        5'd3, 5'd4, 5'd5: rq = "R5";
        5'd6, 5'd7: rq = "R6";
        default: rq = "R7";
      endcase
      tm = (i % 2 == 0) ? 32'hF0F0_00A2 : 32'hF0F0_00A1;  // R1 unrelated bits pass through
      fire(rq, VECS[i][8:4], 32'h0000_A500 | {28'd0, VECS[i][3:0]}, 32'h0000_4000 + 32'(i * 16));
    end

    // R8: unknown cause, outputs hold, sticky error
    fire("R8", 5'd0, 32'h0000_0003, 32'h0000_5000);
    fire("R8", 5'd31, 32'h0000_0007, 32'h0000_5004);
    // R8: interrupt with PIE clear is rejected
    fire("R8", 5'd1, 32'h0000_0002, 32'h0000_5008);
    // R8 sticky across a legal entry; R10 PC wrap
    fire("R10", 5'd7, 32'h0000_0001, 32'hFFFF_FFFC);
    fire("R10", 5'd8, 32'h0000_0003, 32'hFFFF_FFFE);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule